// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control sequencer and architectural register set of a small accumulator machine. Each instruction passes through numbered timing slots. Slots T0 to T2 fetch the word and are the same for every instruction. Slot T3 resolves the operand address. Slots T4 to T6 carry out memory-reference work. The block owns the program counter, the memory address and memory data registers, the instruction register, the accumulator and an interrupt-enable flag. It drives a single-port memory whose address always comes from the memory address register and whose write data always comes from the memory data register.

An instruction word has an indirect flag in its top bit and a 3-bit opcode below it. The low ADDR_W bits hold the address, or a set of micro-operation bits. Opcodes 0 to 6 are AND, ADD, LDA, STA, BUN, BSA and ISZ. Opcode 7 is a register instruction when the indirect flag is 0 and an I/O instruction when it is 1. Slot T3 splits three ways:

- An indirect operand pointer is read in T3.
- A direct operand does nothing in T3.
- Register and I/O work finishes in T3.

An interrupt request is honoured only at an instruction boundary, and only while the enable flag is set. The return address is saved to a fixed location and control continues at a fixed vector.

Memory reads are zero-wait: `mem_rdata` must show the word at `mem_addr` in the same cycle that `mem_rd` is high. A write takes effect at the clock edge that ends the `mem_wr` cycle.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, PC equals START_ADDR (default 0x010), the accumulator is 0, halted is 0, both strobes are 0 and boundary is 1.
- R2: mem_rd and mem_wr are never high in the same cycle, and every write stores the value the executing instruction defines.
- R3: Each fetch reads the word at PC in T1 and increments PC exactly once, so the next boundary of a non-branching instruction shows PC+1.
- R4: Opcode 7 with indirect bit 0 takes 4 cycles. Its micro-operation bits act by priority, and only the highest set bit acts: bit 11 clears AC, bit 10 complements AC, bit 9 increments AC, bit 8 skips the next word if AC is zero, bit 7 halts.
- R5: Opcode 7 with indirect bit 1 takes 4 cycles. Bit 7 sets the interrupt enable, and otherwise bit 6 clears it.
- R6: With bit 15 set, T3 reads the word at the address field, and its low 12 bits become the effective address. This adds no cycles over the direct form.
- R7: AND, ADD and LDA take 6 cycles and give AC&M, (AC+M) mod 2^16 and M.
- R8: STA takes 6 cycles and writes AC to the effective address.
- R9: BUN takes 5 cycles and loads PC with the effective address. BSA takes 7 cycles, stores the return address at the effective address and continues at the effective address plus 1.
- R10: ISZ takes 7 cycles and writes back the incremented word. It skips the next word only when the result is zero.
- R11: At a boundary with the enable set and irq high, the entry takes 3 cycles from boundary to boundary. It writes PC to address SAVE_ADDR (0), sets PC to VEC_ADDR (1) and clears the enable. Nothing happens at a boundary where the enable is clear.
- R12: A halt sets halted 4 cycles after its boundary. After that, no strobe is issued and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Write data (memory data register) |
| mem_rdata | input | 16 | Read data, valid in the same cycle as mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| irq | input | 1 | Level interrupt request |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| boundary | output | 1 | High in slot T0, the instruction boundary |
| halted | output | 1 | Machine halted |

## Verification
The bench measures the distance between boundaries and the PC at each boundary against a precomputed trace, so any slot count that is off by one shows up at once.

- The two-bit micro-operation word must let only the clear act. A design that let every set bit act would leave a complemented value in AC.
- An ISZ that wraps to zero must skip, while one that does not wrap must not. Testing the wrong flag moves the PC trace.
- An interrupt must be taken after I/O enables it, must return through an indirect branch, and must be refused after I/O disables it. A design that sampled the request without the enable would vector early and corrupt the trace.
- The halt must fall exactly 4 cycles after its boundary and stay quiet afterwards. A design that kept fetching would show strobes.

// File: rtl/ic_pkg.sv
package ic_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_AND = 3'd0;
   localparam logic [OPC_W-1:0] OPC_ADD = 3'd1;
   localparam logic [OPC_W-1:0] OPC_LDA = 3'd2;
   localparam logic [OPC_W-1:0] OPC_STA = 3'd3;
   localparam logic [OPC_W-1:0] OPC_BUN = 3'd4;
   localparam logic [OPC_W-1:0] OPC_BSA = 3'd5;
   localparam logic [OPC_W-1:0] OPC_ISZ = 3'd6;
   localparam logic [OPC_W-1:0] OPC_REG = 3'd7;

   typedef enum logic [3:0] {
      S_T0, S_T1, S_T2, S_T3, S_T4, S_T5, S_T6,
      S_INT0, S_INT1, S_HALT
   } slot_e;

   typedef enum logic [2:0] {
      ALU_PASSA, ALU_AND, ALU_ADD, ALU_PASSB,
      ALU_INCB, ALU_CLR, ALU_NOTA, ALU_INCA
   } alu_op_e;

   typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_MAR, PC_VEC} pc_sel_e;
   typedef enum logic [2:0] {MAR_HOLD, MAR_PC, MAR_MDR, MAR_RD, MAR_INC, MAR_SAVE} mar_sel_e;
   typedef enum logic [2:0] {MDR_HOLD, MDR_RD, MDR_AC, MDR_PC, MDR_ALU} mdr_sel_e;

   typedef struct packed {
      logic     mem_rd;
      logic     mem_wr;
      pc_sel_e  pc_sel;
      mar_sel_e mar_sel;
      mdr_sel_e mdr_sel;
      logic     ir_ld;
      logic     ac_ld;
      logic     ien_set;
      logic     ien_clr;
   } ctl_t;

endpackage

// File: rtl/ic_alu.sv
module ic_alu
   import ic_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  alu_op_e      op_i,
   output logic [W-1:0] res_o,
   output logic         zero_o
);

   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      unique case (op_i)
         ALU_AND:   res_o = a_i & b_i;
         ALU_ADD:   res_o = a_i + b_i;
         ALU_PASSB: res_o = b_i;
         ALU_INCB:  res_o = b_i + ONE;
         ALU_CLR:   res_o = '0;
         ALU_NOTA:  res_o = ~a_i;
         ALU_INCA:  res_o = a_i + ONE;
         default:   res_o = a_i;
      endcase
   end

   assign zero_o = (res_o == '0);

endmodule

// File: rtl/ic_seq.sv
module ic_seq
   import ic_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ind_i,
   input  logic [OPC_W-1:0]  op_i,
   input  logic [ADDR_W-1:0] fn_i,
   input  logic              zero_i,
   input  logic              ien_i,
   input  logic              irq_i,
   output slot_e             st_o,
   output ctl_t              ctl_o,
   output alu_op_e           alu_op_o
);

   localparam int B_CLR = ADDR_W - 1;
   localparam int B_CMP = ADDR_W - 2;
   localparam int B_INC = ADDR_W - 3;
   localparam int B_SKZ = ADDR_W - 4;
   localparam int B_HLT = ADDR_W - 5;
   localparam int B_ION = ADDR_W - 5;
   localparam int B_IOF = ADDR_W - 6;

   slot_e st, nxt;
   ctl_t  c;
   logic  is_reg, is_io;

   assign is_reg = (op_i == OPC_REG) && !ind_i;
   assign is_io  = (op_i == OPC_REG) && ind_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_T0;
      else        st <= nxt;
   end

   // ALU selection never depends on the zero flag
   always_comb begin
      alu_op_o = ALU_PASSA;
      unique case (st)
         S_T3: if (is_reg) begin
            if (fn_i[B_CLR])      alu_op_o = ALU_CLR;
            else if (fn_i[B_CMP]) alu_op_o = ALU_NOTA;
            else if (fn_i[B_INC]) alu_op_o = ALU_INCA;
            else                  alu_op_o = ALU_PASSA;
         end
         S_T5: begin
            unique case (op_i)
               OPC_AND: alu_op_o = ALU_AND;
               OPC_ADD: alu_op_o = ALU_ADD;
               OPC_LDA: alu_op_o = ALU_PASSB;
               OPC_ISZ: alu_op_o = ALU_INCB;
               default: alu_op_o = ALU_PASSA;
            endcase
         end
         S_T6:    alu_op_o = ALU_PASSB;
         default: alu_op_o = ALU_PASSA;
      endcase
   end

   always_comb begin
      nxt = st;
      c   = '0;
      unique case (st)
         S_T0: begin
            if (ien_i && irq_i) nxt = S_INT0;
            else begin
               c.mar_sel = MAR_PC;
               nxt       = S_T1;
            end
         end
         S_INT0: begin
            c.mar_sel = MAR_SAVE;
            c.mdr_sel = MDR_PC;
            nxt       = S_INT1;
         end
         S_INT1: begin
            c.mem_wr  = 1'b1;
            c.pc_sel  = PC_VEC;
            c.ien_clr = 1'b1;
            nxt       = S_T0;
         end
         S_T1: begin
            c.mem_rd  = 1'b1;
            c.mdr_sel = MDR_RD;
            c.pc_sel  = PC_INC;
            nxt       = S_T2;
         end
         S_T2: begin
            c.ir_ld   = 1'b1;
            c.mar_sel = MAR_MDR;
            nxt       = S_T3;
         end
         S_T3: begin
            if (is_reg) begin
               nxt = S_T0;
               if (fn_i[B_CLR] || fn_i[B_CMP] || fn_i[B_INC]) c.ac_ld = 1'b1;
               else if (fn_i[B_SKZ]) begin
                  if (zero_i) c.pc_sel = PC_INC;
               end
               else if (fn_i[B_HLT]) nxt = S_HALT;
            end
            else if (is_io) begin
               nxt = S_T0;
               if (fn_i[B_ION])      c.ien_set = 1'b1;
               else if (fn_i[B_IOF]) c.ien_clr = 1'b1;
            end
            else begin
               nxt = S_T4;
               if (ind_i) begin
                  c.mem_rd  = 1'b1;
                  c.mar_sel = MAR_RD;
               end
            end
         end
         S_T4: begin
            unique case (op_i)
               OPC_AND, OPC_ADD, OPC_LDA, OPC_ISZ: begin
                  c.mem_rd  = 1'b1;
                  c.mdr_sel = MDR_RD;
                  nxt       = S_T5;
               end
               OPC_STA: begin
                  c.mdr_sel = MDR_AC;
                  nxt       = S_T5;
               end
               OPC_BUN: begin
                  c.pc_sel = PC_MAR;
                  nxt      = S_T0;
               end
               OPC_BSA: begin
                  c.mdr_sel = MDR_PC;
                  nxt       = S_T5;
               end
               default: nxt = S_T0;
            endcase
         end
         S_T5: begin
            unique case (op_i)
               OPC_AND, OPC_ADD, OPC_LDA: begin
                  c.ac_ld = 1'b1;
                  nxt     = S_T0;
               end
               OPC_STA: begin
                  c.mem_wr = 1'b1;
                  nxt      = S_T0;
               end
               OPC_BSA: begin
                  c.mem_wr  = 1'b1;
                  c.mar_sel = MAR_INC;
                  nxt       = S_T6;
               end
               OPC_ISZ: begin
                  c.mdr_sel = MDR_ALU;
                  nxt       = S_T6;
               end
               default: nxt = S_T0;
            endcase
         end
         S_T6: begin
            nxt = S_T0;
            if (op_i == OPC_BSA) c.pc_sel = PC_MAR;
            else if (op_i == OPC_ISZ) begin
               c.mem_wr = 1'b1;
               if (zero_i) c.pc_sel = PC_INC;
            end
         end
         S_HALT:  nxt = S_HALT;
         default: nxt = S_T0;
      endcase
   end

   assign st_o  = st;
   assign ctl_o = c;

   assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HALT) |=> (st == S_HALT) && !c.mem_rd && !c.mem_wr);

   assert_mem_slots_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_T6) |=> (st == S_T0));

endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
   import ic_pkg::*;
#(
   parameter int                WORD_W     = 16,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [ADDR_W-1:0] SAVE_ADDR  = '0,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl_i,
   input  logic [WORD_W-1:0] rdata_i,
   input  logic [WORD_W-1:0] alu_res_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] mar_o,
   output logic [WORD_W-1:0] mdr_o,
   output logic [WORD_W-1:0] ir_o,
   output logic [WORD_W-1:0] ac_o,
   output logic              ien_o
);

   localparam int PAD_W = WORD_W - ADDR_W;
   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

   logic [WORD_W-1:0] pc_wide;
   assign pc_wide = {{PAD_W{1'b0}}, pc_o};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o  <= START_ADDR;
         mar_o <= '0;
         mdr_o <= '0;
         ir_o  <= '0;
         ac_o  <= '0;
         ien_o <= 1'b0;
      end
      else begin
         unique case (ctl_i.pc_sel)
            PC_INC:  pc_o <= pc_o + A_ONE;
            PC_MAR:  pc_o <= mar_o;
            PC_VEC:  pc_o <= VEC_ADDR;
            default: pc_o <= pc_o;
         endcase
         unique case (ctl_i.mar_sel)
            MAR_PC:   mar_o <= pc_o;
            MAR_MDR:  mar_o <= mdr_o[ADDR_W-1:0];
            MAR_RD:   mar_o <= rdata_i[ADDR_W-1:0];
            MAR_INC:  mar_o <= mar_o + A_ONE;
            MAR_SAVE: mar_o <= SAVE_ADDR;
            default:  mar_o <= mar_o;
         endcase
         unique case (ctl_i.mdr_sel)
            MDR_RD:  mdr_o <= rdata_i;
            MDR_AC:  mdr_o <= ac_o;
            MDR_PC:  mdr_o <= pc_wide;
            MDR_ALU: mdr_o <= alu_res_i;
            default: mdr_o <= mdr_o;
         endcase
         if (ctl_i.ir_ld) ir_o <= mdr_o;
         if (ctl_i.ac_ld) ac_o <= alu_res_i;
         if (ctl_i.ien_set)      ien_o <= 1'b1;
         else if (ctl_i.ien_clr) ien_o <= 1'b0;
      end
   end

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
   import ic_pkg::*;
#(
   parameter int                WORD_W     = 16,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] START_ADDR = 12'h010,
   parameter logic [ADDR_W-1:0] SAVE_ADDR  = 12'h000,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = 12'h001
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic              irq,
   output logic [WORD_W-1:0] acc,
   output logic [ADDR_W-1:0] pc,
   output logic              boundary,
   output logic              halted
);

   localparam int IND_B  = WORD_W - 1;
   localparam int OPC_HI = WORD_W - 2;

   if (WORD_W < ADDR_W + OPC_W + 1) begin : g_bad_word
      $error("instr_cycle_ctrl: WORD_W too narrow for indirect, opcode and address");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("instr_cycle_ctrl: ADDR_W must leave room for six micro-operation bits");
   end

   slot_e             st;
   ctl_t              ctl;
   alu_op_e           alu_op;
   logic [WORD_W-1:0] alu_res, mdr, ir;
   logic [ADDR_W-1:0] mar;
   logic              zero, ien;
   logic [OPC_W-1:0]  opc;

   assign opc = ir[OPC_HI -: OPC_W];

   ic_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ind_i    (ir[IND_B]),
      .op_i     (opc),
      .fn_i     (ir[ADDR_W-1:0]),
      .zero_i   (zero),
      .ien_i    (ien),
      .irq_i    (irq),
      .st_o     (st),
      .ctl_o    (ctl),
      .alu_op_o (alu_op)
   );

   ic_alu #(.W(WORD_W)) u_alu (
      .a_i    (acc),
      .b_i    (mdr),
      .op_i   (alu_op),
      .res_o  (alu_res),
      .zero_o (zero)
   );

   ic_datapath #(
      .WORD_W     (WORD_W),
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR),
      .SAVE_ADDR  (SAVE_ADDR),
      .VEC_ADDR   (VEC_ADDR)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_i     (ctl),
      .rdata_i   (mem_rdata),
      .alu_res_i (alu_res),
      .pc_o      (pc),
      .mar_o     (mar),
      .mdr_o     (mdr),
      .ir_o      (ir),
      .ac_o      (acc),
      .ien_o     (ien)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mdr;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign boundary  = (st == S_T0);
   assign halted    = (st == S_HALT);

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_fetch_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_T1) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

   assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_T2) |=> $stable(ir));

   assert_branch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_T4 && opc == OPC_BUN) |=> (pc == $past(mar)));

   assert_entry_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_INT1) |=> !ien && (pc == VEC_ADDR));

endmodule

// File: tb/instr_cycle_ctrl_bench.sv
module instr_cycle_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b1;
   logic [11:0] mem_addr, pc;
   logic [15:0] mem_wdata, mem_rdata, acc;
   logic        mem_rd, mem_wr, boundary, halted;

   logic [15:0] mem [0:255];

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int last_b = 0;
   int nb = 0;
   int overlap = 0;
   int halt_strobes = 0;
   bit seen_halt = 1'b0;

   typedef struct {
      int    cycles;
      int    pc;
      string tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   instr_cycle_ctrl u_instr_cycle_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .irq       (irq),
      .acc       (acc),
      .pc        (pc),
      .boundary  (boundary),
      .halted    (halted)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(int c, int p, string tag);
      exp_t e;
      e.cycles = c;
      e.pc = p;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: pops one expected item per instruction boundary
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t e;
         cyc++;
         if (mem_rd && mem_wr) overlap++;
         if (halted && (mem_rd || mem_wr)) halt_strobes++;
         if (mem_wr && mem_addr == 12'h000) irq = 1'b0;
         if (boundary) begin
            if (q.size() == 0) chk("R3 unexpected boundary", pc, -1);
            else begin
               e = q.pop_front();
               if (e.cycles >= 0) chk({e.tag, " cycles"}, cyc - last_b, e.cycles);
               chk({e.tag, " pc"}, pc, e.pc);
            end
            last_b = cyc;
            nb++;
            if (nb == 22) irq = 1'b1;
         end
         if (halted && !seen_halt) begin
            seen_halt = 1'b1;
            chk("R12 halt latency", cyc - last_b, 4);
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      // service routine
      mem[8'h01] = 16'h2048; mem[8'h02] = 16'h3049;
      mem[8'h03] = 16'hF080; mem[8'h04] = 16'hC000;
      // main program
      mem[8'h10] = 16'h2040; mem[8'h11] = 16'h9041; mem[8'h12] = 16'h0043;
      mem[8'h13] = 16'h3044; mem[8'h14] = 16'h7400; mem[8'h15] = 16'h7200;
      mem[8'h16] = 16'h7C00; mem[8'h17] = 16'h7100; mem[8'h18] = 16'h7080;
      mem[8'h19] = 16'h6045; mem[8'h1A] = 16'h7080; mem[8'h1B] = 16'h6046;
      mem[8'h1C] = 16'h5050; mem[8'h1D] = 16'h4020;
      mem[8'h20] = 16'hF080; mem[8'h21] = 16'h2047; mem[8'h22] = 16'hF040;
      mem[8'h23] = 16'h104A; mem[8'h24] = 16'h7080;
      mem[8'h51] = 16'hC050;
      // data
      mem[8'h40] = 16'h0005; mem[8'h41] = 16'h0042; mem[8'h42] = 16'h0003;
      mem[8'h43] = 16'h000C; mem[8'h45] = 16'hFFFF; mem[8'h46] = 16'h0007;
      mem[8'h47] = 16'h0077; mem[8'h48] = 16'h0100; mem[8'h4A] = 16'hFFFF;

      push(-1, 'h10, "R1 first boundary");
      push(6, 'h11, "R7 LDA direct");
      push(6, 'h12, "R6 ADD indirect");
      push(6, 'h13, "R7 AND");
      push(6, 'h14, "R8 STA");
      push(4, 'h15, "R4 complement");
      push(4, 'h16, "R4 increment");
      push(4, 'h17, "R4 priority clear");
      push(4, 'h19, "R4 skip on zero");
      push(7, 'h1B, "R10 ISZ wrap skips");
      push(7, 'h1C, "R10 ISZ no skip");
      push(7, 'h51, "R9 BSA");
      push(5, 'h1D, "R9 BUN indirect");
      push(5, 'h20, "R9 BUN direct");
      push(4, 'h21, "R5 enable");
      push(3, 'h01, "R11 entry");
      push(6, 'h02, "R7 LDA in handler");
      push(6, 'h03, "R8 STA in handler");
      push(4, 'h04, "R5 re-enable");
      push(5, 'h21, "R11 return");
      push(6, 'h22, "R7 LDA resumed");
      push(4, 'h23, "R5 disable");
      push(6, 'h24, "R11 masked request");

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pc", pc, 'h010);
      chk("R1 reset acc", acc, 0);
      chk("R1 reset halted", halted, 0);
      chk("R1 reset strobes", {mem_rd, mem_wr}, 0);
      chk("R1 reset boundary", boundary, 1);
      @(posedge clk);
      #1 rst_n = 1'b1;

      while (!halted && cyc < 20000) @(negedge clk);
      if (!halted) chk("R12 watchdog expired", 0, 1);
      repeat (6) @(negedge clk);

      chk("R12 still halted", halted, 1);
      chk("R12 no strobes in halt", halt_strobes, 0);
      chk("R2 strobe overlap", overlap, 0);
      chk("R7 final acc", acc, 16'h0076);
      chk("R8 STA stored", mem[8'h44], 16'h0008);
      chk("R8 handler STA stored", mem[8'h49], 16'h0100);
      chk("R10 ISZ wrap value", mem[8'h45], 16'h0000);
      chk("R10 ISZ plain value", mem[8'h46], 16'h0008);
      chk("R9 BSA return word", mem[8'h50], 16'h001D);
      chk("R11 saved pc", mem[8'h00], 16'h0021);
      chk("R3 trace consumed", q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule